// File: doc/BRIEF.md
# Link Code Word Arbitration Controller

This block makes the decision step of twisted-pair auto-negotiation for 10 Mb/s half and full duplex. It does not touch pulses. A front end that decodes the link code words delivers each complete 16-bit word with a one-cycle `lcw_valid` strobe. A separate detector raises `idle_det` when the partner sends plain 10BASE-T idle instead of words. A free-running `tick` provides the timebase for the link-fail timer.

While the block advertises, it looks for three matching partner words in a row, with the acknowledge bit (bit 14) excluded from the comparison. It stores that word as the partner's ability and raises `tx_ack`, so the transmitter sets acknowledge in the local word. It then waits for three matching words that carry acknowledge, and picks the best duplex mode that both sides support. If the partner sends idle instead, the block treats it as a partner that cannot negotiate and settles on half duplex.

A strap pin fixes whether negotiation may be enabled. The technology pins bound which duplex abilities software may advertise. A home-network mode select holds the block silent.

Top module: `lcw_arbiter`

## Requirements
- R1: Reset behaviour. After reset, `an_enable` equals `strap_an_en`, `local_adv[6:5]` equals `tech_sel` (bit 6 is full, bit 5 is half), and `local_adv[4:0]` is 5'b00001 with every other bit zero. `an_done` and `an_fail` are 0. One clock after reset is released, `advertising` is 1 if negotiation is enabled and home-network mode is off.
- R2: While advertising with `tx_ack` low, the third consecutive partner word that matches in every bit except bit 14 is stored in `partner_ab`, and `tx_ack` rises on the same edge.
- R3: A word that differs from the current candidate (bit 14 excluded) becomes the new candidate, and the match count restarts at one.
- R4: While `tx_ack` is high, a word with bit 14 clear sets the count to zero. The third consecutive identical word with bit 14 set completes negotiation: `an_done` becomes 1, `advertising` and `tx_ack` become 0, and `an_fail` is cleared.
- R5: On completion, `full_duplex` is 1 if both `local_adv[6]` and the partner's bit 6 are set. Otherwise it is 0 if both bit 5s are set. If neither pair is shared, `an_fail` becomes 1 and advertising restarts from the first phase.
- R6: `idle_det` while advertising completes negotiation with `parallel_det` at 1 and `full_duplex` at 0.
- R7: A count of `TIMEOUT_TICKS` ticks since advertising last started, with no completion, sets `an_fail` and restarts the first phase with the match count cleared.
- R8: A control write with `ctl_restart` at 1, while enabled, raises `an_restart` for exactly one cycle. On the following edge advertising restarts with `an_done`, `an_fail` and the match count cleared.
- R9: With the strap high, software may clear `an_enable`, and `advertising` then falls. With the strap low, `an_enable` stays 0 and writes to it are ignored.
- R10: While `hnet_sel` is 1, the block does not advertise and `an_done` stays 0, even when partner words arrive.
- R11: An ability write loads `local_adv[6:5]` with `adv_ab_wr & tech_sel`. A bit can therefore always be cleared, but can only be set if its technology pin allows it.
- R12: `link_lost` while negotiation is complete clears `an_done` and restarts advertising on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_an_en | input | 1 | Strap pin: negotiation allowed and enabled after reset |
| tech_sel | input | 2 | Technology pins: [1] full duplex allowed, [0] half duplex allowed |
| hnet_sel | input | 1 | Home-network mode select; negotiation off |
| ctl_we | input | 1 | Control register write strobe |
| ctl_an_en | input | 1 | Written value of the enable bit |
| ctl_restart | input | 1 | Written value of the restart bit |
| adv_we | input | 1 | Ability register write strobe |
| adv_ab_wr | input | 2 | Written ability bits: [1] full, [0] half |
| tick | input | 1 | Timebase tick for the link-fail timer |
| link_lost | input | 1 | Link dropped after completion |
| idle_det | input | 1 | Partner idle pattern detected |
| lcw_valid | input | 1 | Decoded partner word strobe |
| lcw_data | input | 16 | Decoded partner word; bit 14 is acknowledge |
| an_enable | output | 1 | Negotiation enable bit |
| an_restart | output | 1 | Restart bit; clears itself once the restart is taken |
| advertising | output | 1 | Local words are being sent |
| tx_ack | output | 1 | Acknowledge bit of the local word |
| an_done | output | 1 | Negotiation complete |
| an_fail | output | 1 | Negotiation failed; a restart is in progress |
| full_duplex | output | 1 | Resolved duplex: 1 full, 0 half |
| parallel_det | output | 1 | Resolution came from the idle pattern |
| partner_ab | output | 16 | Stored partner ability word |
| local_adv | output | 16 | Local advertised ability word |

## Verification
The hardest state to reach is a link-fail timeout that lands while a partial match is in progress. Two matching words must be held pending while exactly `TIMEOUT_TICKS` ticks go by with no completion. The bench then has to show that the count was discarded, so a single further matching word must not raise acknowledge. The bench reaches this state with directed tick pulses after two words, and checks one cycle before and one cycle after the limit. Random rounds then mix ability writes, partner abilities, a random acknowledge bit in the first phase and a near-miss word ahead of each sequence, and check the resolved duplex or the failure against a reference function.

// File: rtl/lcw_arbiter.sv
module lcw_arbiter #(
  parameter int TIMEOUT_TICKS = 50,
  parameter int MATCH_CNT     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_an_en,
  input  logic [1:0]  tech_sel,
  input  logic        hnet_sel,
  input  logic        ctl_we,
  input  logic        ctl_an_en,
  input  logic        ctl_restart,
  input  logic        adv_we,
  input  logic [1:0]  adv_ab_wr,
  input  logic        tick,
  input  logic        link_lost,
  input  logic        idle_det,
  input  logic        lcw_valid,
  input  logic [15:0] lcw_data,
  output logic        an_enable,
  output logic        an_restart,
  output logic        advertising,
  output logic        tx_ack,
  output logic        an_done,
  output logic        an_fail,
  output logic        full_duplex,
  output logic        parallel_det,
  output logic [15:0] partner_ab,
  output logic [15:0] local_adv
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam int CW = $clog2(MATCH_CNT + 1);
  localparam logic [15:0] ACK_MASK = 16'hBFFF;

  typedef enum logic [1:0] {ST_OFF, ST_ABIL, ST_ACK, ST_DONE} st_t;

  st_t           state;
  logic [15:0]   cand;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic [1:0]    ab;

  wire run      = an_enable && !hnet_sel;
  wire same_w   = ((lcw_data ^ cand) & ACK_MASK) == 16'h0;
  wire last_m   = cnt == CW'(MATCH_CNT - 1);
  wire t_out    = tick && tmr == TW'(TIMEOUT_TICKS - 1);
  wire fd_ok    = ab[1] && lcw_data[6];
  wire hd_ok    = ab[0] && lcw_data[5];

  assign local_adv   = {9'b0, ab, 5'b00001};
  assign advertising = state == ST_ABIL || state == ST_ACK;
  assign tx_ack      = state == ST_ACK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      an_enable  <= strap_an_en;
      ab         <= tech_sel;
      an_restart <= 1'b0;
    end else begin
      if (ctl_we && strap_an_en) an_enable <= ctl_an_en;
      if (adv_we) ab <= adv_ab_wr & tech_sel;
      an_restart <= ctl_we && ctl_restart && an_enable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_OFF;
      cand         <= '0;
      cnt          <= '0;
      tmr          <= '0;
      an_done      <= 1'b0;
      an_fail      <= 1'b0;
      full_duplex  <= 1'b0;
      parallel_det <= 1'b0;
      partner_ab   <= '0;
    end else if (!run) begin
      state   <= ST_OFF;
      cnt     <= '0;
      tmr     <= '0;
      an_done <= 1'b0;
    end else if (an_restart || state == ST_OFF || (state == ST_DONE && link_lost)) begin
      state        <= ST_ABIL;
      cnt          <= '0;
      tmr          <= '0;
      an_done      <= 1'b0;
      full_duplex  <= 1'b0;
      parallel_det <= 1'b0;
      if (an_restart) an_fail <= 1'b0;
    end else if (advertising) begin
      if (t_out) begin
        an_fail <= 1'b1;
        state   <= ST_ABIL;
        cnt     <= '0;
        tmr     <= '0;
      end else begin
        if (tick) tmr <= tmr + 1'b1;
        if (idle_det) begin
          state        <= ST_DONE;
          an_done      <= 1'b1;
          an_fail      <= 1'b0;
          full_duplex  <= 1'b0;
          parallel_det <= 1'b1;
        end else if (lcw_valid) begin
          if (state == ST_ACK && !lcw_data[14]) begin
            cnt <= '0;
          end else if (cnt != '0 && same_w) begin
            if (!last_m) begin
              cnt <= cnt + 1'b1;
            end else if (state == ST_ABIL) begin
              partner_ab <= lcw_data;
              state      <= ST_ACK;
              cnt        <= '0;
            end else if (fd_ok || hd_ok) begin
              state        <= ST_DONE;
              an_done      <= 1'b1;
              an_fail      <= 1'b0;
              full_duplex  <= fd_ok;
              parallel_det <= 1'b0;
            end else begin
              an_fail <= 1'b1;
              state   <= ST_ABIL;
              cnt     <= '0;
              tmr     <= '0;
            end
          end else begin
            cand <= lcw_data;
            cnt  <= CW'(1);
          end
        end
      end
    end
  end

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    an_done |-> !advertising && !tx_ack); // R4
  AST_DONE_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(an_done) |-> parallel_det || $past(tx_ack)); // R4
  AST_PARALLEL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    parallel_det |-> !full_duplex); // R6
  AST_FAIL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(an_fail) |-> advertising && !tx_ack); // R7
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart && !(ctl_we && ctl_restart) |=> !an_restart); // R8
  AST_STRAP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_an_en && !an_enable |=> !an_enable); // R9
  AST_HNET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hnet_sel |=> !advertising && !an_done); // R10
endmodule

// File: tb/lcw_arbiter_tb_top.sv
module lcw_arbiter_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic strap_an_en = 1, hnet_sel = 0;
  logic [1:0] tech_sel = 2'b11;
  logic ctl_we = 0, ctl_an_en = 0, ctl_restart = 0, adv_we = 0;
  logic [1:0] adv_ab_wr = 0;
  logic tick = 0, link_lost = 0, idle_det = 0, lcw_valid = 0;
  logic [15:0] lcw_data = 0;
  logic an_enable, an_restart, advertising, tx_ack, an_done, an_fail;
  logic full_duplex, parallel_det;
  logic [15:0] partner_ab, local_adv;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lcw_arbiter dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(logic strap, logic [1:0] tech, logic hn);
    strap_an_en = strap; tech_sel = tech; hnet_sel = hn; rst_n = 0;
    step(2);
    rst_n = 1;
  endtask

  task automatic send(logic [15:0] w);
    lcw_data = w; lcw_valid = 1; step(); lcw_valid = 0;
  endtask

  task automatic ctl_write(logic en, logic rs);
    ctl_we = 1; ctl_an_en = en; ctl_restart = rs; step(); ctl_we = 0; ctl_restart = 0;
  endtask

  task automatic adv_write(logic [1:0] v);
    adv_we = 1; adv_ab_wr = v; step(); adv_we = 0;
  endtask

  task automatic pulse_tick();
    tick = 1; step(); tick = 0;
  endtask

  task automatic restart();
    ctl_write(1, 1); step();
  endtask

  function automatic logic [1:0] resolve(logic [1:0] la, logic [15:0] pw);
    if (la[1] && pw[6]) return 2'b11;
    if (la[0] && pw[5]) return 2'b10;
    return 2'b00;
  endfunction

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [15:0] w, b;
    logic [1:0] la, r;
    void'($urandom(32'h5EED));

    do_reset(1, 2'b11, 0);
    chk("R1 enable", an_enable, 1);
    chk("R1 adv", local_adv, 16'h0061);
    chk("R1 done", {an_done, an_fail}, 0);
    chk("R1 not yet", advertising, 0);
    step();
    chk("R1 advertising", advertising, 1);

    send(16'h0061); send(16'h4061);
    chk("R2 two words", tx_ack, 0);
    send(16'h0061);
    chk("R2 ack", tx_ack, 1);
    chk("R2 partner", partner_ab, 16'h0061);

    send(16'h4061); send(16'h4061); send(16'h0061);
    send(16'h4061); send(16'h4061);
    chk("R4 no-ack reset", an_done, 0);
    send(16'h4061);
    chk("R4 done", {an_done, advertising, tx_ack}, 3'b100);
    chk("R5 full", full_duplex, 1);

    ctl_write(1, 1);
    chk("R8 restart bit", an_restart, 1);
    chk("R8 not yet", an_done, 1);
    step();
    chk("R8 self clear", an_restart, 0);
    chk("R8 readvertise", {an_done, advertising, tx_ack}, 3'b010);

    send(16'h0061); send(16'h0061); send(16'h0021); send(16'h0021);
    chk("R3 new candidate", tx_ack, 0);
    send(16'h4021);
    chk("R3 ack", tx_ack, 1);
    chk("R3 partner", partner_ab, 16'h4021);
    restart();

    adv_write(2'b01);
    chk("R11 half only", local_adv, 16'h0021);
    for (int i = 0; i < 3; i++) send(16'h0041);
    for (int i = 0; i < 3; i++) send(16'h4041);
    chk("R5 no common", {an_fail, an_done, advertising, tx_ack}, 4'b1010);

    idle_det = 1; step(); idle_det = 0;
    chk("R6 parallel", {an_done, parallel_det, full_duplex, an_fail}, 4'b1100);

    link_lost = 1; step(); link_lost = 0;
    chk("R12 relink", {an_done, advertising}, 2'b01);

    send(16'h0021); send(16'h0021);
    for (int i = 0; i < 49; i++) pulse_tick();
    chk("R7 before limit", an_fail, 0);
    pulse_tick();
    chk("R7 timeout", {an_fail, advertising, tx_ack}, 3'b110);
    send(16'h0021);
    chk("R7 count cleared", tx_ack, 0);
    send(16'h0021); send(16'h0021);
    chk("R7 ack after restart", tx_ack, 1);

    ctl_write(0, 0);
    chk("R9 cleared", an_enable, 0);
    step();
    chk("R9 silent", advertising, 0);
    ctl_write(1, 0); step();
    chk("R9 reenabled", advertising, 1);

    do_reset(0, 2'b11, 0);
    chk("R1 strap low", an_enable, 0);
    ctl_write(1, 0); step();
    chk("R9 strap lock", {an_enable, advertising}, 2'b00);

    do_reset(1, 2'b11, 1);
    step(2);
    chk("R10 quiet", advertising, 0);
    for (int i = 0; i < 3; i++) send(16'h0061);
    for (int i = 0; i < 3; i++) send(16'h4061);
    chk("R10 no done", an_done, 0);
    hnet_sel = 0; step();
    chk("R10 leave", advertising, 1);

    do_reset(1, 2'b01, 0);
    chk("R1 tech adv", local_adv, 16'h0021);
    adv_write(2'b11);
    chk("R11 masked", local_adv, 16'h0021);
    adv_write(2'b00);
    chk("R11 clear", local_adv, 16'h0001);

    do_reset(1, 2'b11, 0);
    step();
    for (int n = 0; n < 40; n++) begin
      la = 2'($urandom);
      adv_write(la);
      restart();
      w = 16'($urandom) & 16'hBFFF;
      b = 16'($urandom) & 16'h4000;
      send(w ^ 16'h0100);
      send(w); send(w); send(w | b);
      chk("R2 random ack", tx_ack, 1);
      chk("R2 random partner", partner_ab, w | b);
      send(w | 16'h4000); send(w | 16'h4000); send(w | 16'h4000);
      r = resolve(la, w);
      chk("R5 random outcome", {an_done, full_duplex, an_fail}, {r[1], r[0], ~r[1]});
    end
    summary();
  end
endmodule